// File: doc/BRIEF.md
# SCSI Initiator Block-Move Handshake Engine

This block runs a single block-move command for a SCSI initiator on an asynchronous narrow bus. A command carries a byte count, a 3-bit phase code and a start strobe. Before any byte moves, the engine compares the command's phase with the bus phase that was latched when REQ last rose. If the two differ, it raises a one-cycle mismatch interrupt and does nothing more.

When the phases agree, the engine moves the bytes one at a time with the asynchronous REQ/ACK handshake. Inbound bytes are handed to the host as one-cycle `rx_valid_o` pulses. Outbound bytes are pulled from a valid/ready byte stream. The engine handles three special cases:
- At the end of a message-out move, it drops ATN during the last handshake.
- At the end of a message-in move, it keeps ACK asserted until a separate clear-ACK command arrives.
- If the target changes phase partway through a move, it stops and raises the same mismatch interrupt.

With target mode selected, the engine does not compare the phase. It drives the command's phase onto the phase lines instead and completes at once.

Top module: `scsi_bm_initiator`

## Requirements
- R1: Phase bits are ordered {MSG, C/D, I/O}: 000 Data-Out, 001 Data-In, 010 Command, 011 Status, 110 Message-Out, 111 Message-In. I/O=1 means bytes flow into the initiator and `data_oe_o` stays 0. I/O=0 means the initiator drives `data_out_o` with `data_oe_o`=1.
- R2: On start, the command phase is compared with the bus phase latched at the most recent rising edge of REQ. On a difference, `irq_o` pulses for one cycle, ACK never asserts, `done_o` does not pulse and the engine returns to idle.
- R3: A command naming code 100 or 101 always mismatches, even when the bus shows the same code.
- R4: ACK rises only after REQ has been seen high and falls only after REQ has been seen low. On input phases, each byte present on `data_in_i` is delivered once on `rx_data_o` with a one-cycle `rx_valid_o`.
- R5: On output phases, the engine takes exactly one stream byte per handshake, accepted when `tx_valid_i` and `tx_ready_o` are both high. That byte is on `data_out_o` while ACK is high.
- R6: A move of N bytes performs exactly N handshakes and then pulses `done_o` once. A count of zero pulses `done_o` without any handshake, provided the phase matches.
- R7: If REQ rises during a move with a bus phase different from the command's, the move stops without ACK, `irq_o` pulses and `done_o` does not.
- R8: During a Message-Out move with ATN set, ATN stays high for every handshake but the last. ATN falls on the same edge at which ACK rises for the last byte.
- R9: After the last Message-In byte, ACK stays high and `busy_o` stays 1 until `clr_ack_i`. That command then drops ACK and returns the engine to idle.
- R10: `clr_ack_i` has no effect on ACK or on the engine state except while ACK is held after a Message-In move.
- R11: A start with `tgt_mode_i`=1 drives the command phase on `phase_drv_o` with `phase_oe_o`=1 and pulses `done_o`, with no handshake. The phase lines stay driven until the next initiator-mode start.
- R12: After reset, ACK, ATN, `data_oe_o`, `busy_o`, `done_o`, `irq_o` and `phase_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start strobe (accepted when idle) |
| tgt_mode_i | input | 1 | 1 = target mode: drive the phase instead of comparing it |
| cmd_phase_i | input | 3 | Command phase code {MSG, C/D, I/O} |
| cmd_count_i | input | CNT_W | Byte count of the move |
| atn_set_i | input | 1 | Set-ATN command |
| clr_ack_i | input | 1 | Clear-ACK command |
| req_i | input | 1 | REQ from the target |
| bus_phase_i | input | 3 | Bus MSG, C/D, I/O lines |
| data_in_i | input | 8 | Bus data from the target |
| tx_data_i | input | 8 | Outbound stream byte |
| tx_valid_i | input | 1 | Outbound byte available |
| tx_ready_o | output | 1 | Outbound byte taken this cycle |
| rx_data_o | output | 8 | Inbound byte |
| rx_valid_o | output | 1 | Inbound byte strobe |
| ack_o | output | 1 | ACK to the target |
| atn_o | output | 1 | ATN to the target |
| data_out_o | output | 8 | Bus data driven by the initiator |
| data_oe_o | output | 1 | Bus data output enable |
| phase_drv_o | output | 3 | Phase lines driven in target mode |
| phase_oe_o | output | 1 | Phase line output enable |
| busy_o | output | 1 | Engine not idle |
| done_o | output | 1 | Move completed (pulse) |
| irq_o | output | 1 | Phase mismatch interrupt (pulse) |

## Verification
The bench runs moves in all six legal phases with random byte values and random counts. Comparing the bytes received, or the bytes put on the bus, against the bench's own lists separates inbound moves from outbound ones. It also shows that no byte is skipped or repeated. Directed cases cover the remaining behaviour:
- a mismatch at start, and a reserved code, which must both produce an interrupt without any handshake;
- a phase change after the first byte, which shows whether the mid-move check stops the move;
- the message-out and message-in endings, which separate the ATN release and the ACK hold from an ordinary last byte;
- a zero count, a stray clear-ACK, and a target-mode start.

// File: rtl/scsi_bm_pkg.sv
package scsi_bm_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_DATA_OUT = 3'b000,
    PH_DATA_IN  = 3'b001,
    PH_COMMAND  = 3'b010,
    PH_STATUS   = 3'b011,
    PH_RSV_A    = 3'b100,
    PH_RSV_B    = 3'b101,
    PH_MSG_OUT  = 3'b110,
    PH_MSG_IN   = 3'b111
  } bus_phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_REQ,
    S_DRIVE,
    S_WAIT_REL,
    S_HOLD
  } bm_state_e;

  // Reserved codes (MSG=1, C/D=0) can never match the bus.
  function automatic logic phase_match(input logic [PHASE_W-1:0] want,
                                       input logic [PHASE_W-1:0] seen);
    return (want[2:1] != 2'b10) && (want == seen);
  endfunction

  // The I/O bit gives the direction: 1 means into the initiator.
  function automatic logic phase_inbound(input logic [PHASE_W-1:0] ph);
    return ph[0];
  endfunction

endpackage

// File: rtl/scsi_bm_phase_mon.sv
module scsi_bm_phase_mon
  import scsi_bm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [PHASE_W-1:0] bus_phase_i,
  output logic [PHASE_W-1:0] lat_phase_o
);

  logic               req_q;
  logic               req_rise;
  logic [PHASE_W-1:0] lat_q;

  assign req_rise = req_i & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_i;
    end
  end

  // Phase status latch, updated only when REQ rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (req_rise) begin
      lat_q <= bus_phase_i;
    end
  end

  assign lat_phase_o = lat_q;

endmodule

// File: rtl/scsi_bm_counter.sv
module scsi_bm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/scsi_bm_initiator.sv
module scsi_bm_initiator
  import scsi_bm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tgt_mode_i,
  input  logic [2:0]        cmd_phase_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic              atn_set_i,
  input  logic              clr_ack_i,
  input  logic              req_i,
  input  logic [2:0]        bus_phase_i,
  input  logic [DATA_W-1:0] data_in_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              ack_o,
  output logic              atn_o,
  output logic [DATA_W-1:0] data_out_o,
  output logic              data_oe_o,
  output logic [2:0]        phase_drv_o,
  output logic              phase_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);

  bm_state_e          state_q, state_d;
  logic [PHASE_W-1:0] cmd_q, cmd_d;
  logic [PHASE_W-1:0] lat_phase;
  logic               ack_q, ack_d;
  logic               atn_q, atn_d;
  logic               oe_q, oe_d;
  logic [DATA_W-1:0]  dout_q, dout_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               rxv_q, rxv_d;
  logic               done_q, done_d;
  logic               irq_q, irq_d;
  logic [PHASE_W-1:0] pdrv_q, pdrv_d;
  logic               poe_q, poe_d;
  logic               cnt_load, cnt_dec, cnt_last;
  logic               tx_take;
  logic               bus_ok;

  scsi_bm_phase_mon u_phase_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .bus_phase_i (bus_phase_i),
    .lat_phase_o (lat_phase)
  );

  scsi_bm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cmd_count_i),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  assign bus_ok = phase_match(cmd_q, bus_phase_i);

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    ack_d    = ack_q;
    atn_d    = atn_q | atn_set_i;
    oe_d     = oe_q;
    dout_d   = dout_q;
    rx_d     = rx_q;
    rxv_d    = 1'b0;
    done_d   = 1'b0;
    irq_d    = 1'b0;
    pdrv_d   = pdrv_q;
    poe_d    = poe_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    tx_take  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (tgt_mode_i) begin
            pdrv_d = cmd_phase_i;
            poe_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            poe_d = 1'b0;
            cmd_d = cmd_phase_i;
            if (!phase_match(cmd_phase_i, lat_phase)) begin
              irq_d = 1'b1;
            end else if (cmd_count_i == '0) begin
              done_d = 1'b1;
            end else begin
              cnt_load = 1'b1;
              oe_d     = ~phase_inbound(cmd_phase_i);
              state_d  = S_WAIT_REQ;
            end
          end
        end
      end
      S_WAIT_REQ: begin
        if (req_i) begin
          if (!bus_ok) begin
            irq_d   = 1'b1;
            oe_d    = 1'b0;
            state_d = S_IDLE;
          end else if (phase_inbound(cmd_q)) begin
            rx_d    = data_in_i;
            rxv_d   = 1'b1;
            ack_d   = 1'b1;
            state_d = S_WAIT_REL;
          end else if (tx_valid_i) begin
            tx_take = 1'b1;
            dout_d  = tx_data_i;
            state_d = S_DRIVE;
          end
        end
      end
      S_DRIVE: begin
        ack_d = 1'b1;
        if (cnt_last && (cmd_q == PH_MSG_OUT)) begin
          atn_d = 1'b0;
        end
        state_d = S_WAIT_REL;
      end
      S_WAIT_REL: begin
        if (!req_i) begin
          cnt_dec = 1'b1;
          if (cnt_last) begin
            done_d = 1'b1;
            oe_d   = 1'b0;
            if (cmd_q == PH_MSG_IN) begin
              state_d = S_HOLD;
            end else begin
              ack_d   = 1'b0;
              state_d = S_IDLE;
            end
          end else begin
            ack_d   = 1'b0;
            state_d = S_WAIT_REQ;
          end
        end
      end
      S_HOLD: begin
        if (clr_ack_i) begin
          ack_d   = 1'b0;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      ack_q   <= 1'b0;
      atn_q   <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= '0;
      rx_q    <= '0;
      rxv_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      pdrv_q  <= '0;
      poe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ack_q   <= ack_d;
      atn_q   <= atn_d;
      oe_q    <= oe_d;
      dout_q  <= dout_d;
      rx_q    <= rx_d;
      rxv_q   <= rxv_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      pdrv_q  <= pdrv_d;
      poe_q   <= poe_d;
    end
  end

  assign tx_ready_o  = tx_take;
  assign rx_data_o   = rx_q;
  assign rx_valid_o  = rxv_q;
  assign ack_o       = ack_q;
  assign atn_o       = atn_q;
  assign data_out_o  = dout_q;
  assign data_oe_o   = oe_q;
  assign phase_drv_o = pdrv_q;
  assign phase_oe_o  = poe_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/scsi_bm_chk.sv
module scsi_bm_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic clr_ack_i,
  input logic req_i,
  input logic tx_ready_o,
  input logic ack_o,
  input logic atn_o,
  input logic busy_o,
  input logic done_o,
  input logic irq_o
);

  // R4
  ack_rise_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_i));

  // R2
  irq_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !ack_o);

  // R6
  done_irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, irq_o}));

  // R8
  atn_drop_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(atn_o) |-> $rose(ack_o));

  // R5
  tx_take_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !ack_o);

  // R10
  clr_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ack_i && !busy_o && !start_i) |=> (!ack_o && !busy_o));

endmodule

bind scsi_bm_initiator scsi_bm_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .clr_ack_i  (clr_ack_i),
  .req_i      (req_i),
  .tx_ready_o (tx_ready_o),
  .ack_o      (ack_o),
  .atn_o      (atn_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .irq_o      (irq_o)
);

// File: tb/scsi_bm_initiator_tb_top.sv
module scsi_bm_initiator_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, tgt_mode = 1'b0, atn_set = 1'b0, clr_ack = 1'b0;
  logic [2:0]    cmd_phase = '0, bus_phase = '0;
  logic [CW-1:0] cmd_count = '0;
  logic          req = 1'b0, tx_valid = 1'b0, tx_rst = 1'b1;
  logic [7:0]    data_in = '0;
  logic [7:0]    tx_data;
  logic          tx_ready, rx_valid, ack, atn, data_oe, phase_oe, busy, done, irq;
  logic [7:0]    rx_data, data_out;
  logic [2:0]    phase_drv;

  int nchk = 0, nfail = 0;
  int done_cnt = 0, irq_cnt = 0, rx_n = 0, tx_idx = 0;
  logic [7:0] tx_buf [16];
  logic [7:0] in_buf [16];
  logic [7:0] rx_buf [16];

  always #5 clk = ~clk;

  scsi_bm_initiator #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tgt_mode_i(tgt_mode),
    .cmd_phase_i(cmd_phase), .cmd_count_i(cmd_count), .atn_set_i(atn_set),
    .clr_ack_i(clr_ack), .req_i(req), .bus_phase_i(bus_phase), .data_in_i(data_in),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .ack_o(ack), .atn_o(atn),
    .data_out_o(data_out), .data_oe_o(data_oe), .phase_drv_o(phase_drv),
    .phase_oe_o(phase_oe), .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  assign tx_data = tx_buf[tx_idx[3:0]];

  always @(posedge clk) begin
    if (tx_rst) tx_idx <= 0;
    else if (tx_ready) tx_idx <= tx_idx + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt = done_cnt + 1;
      if (irq) irq_cnt = irq_cnt + 1;
      if (rx_valid) begin
        rx_buf[rx_n[3:0]] = rx_data;
        rx_n = rx_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_counts();
    done_cnt = 0; irq_cnt = 0; rx_n = 0;
    tx_rst = 1'b1; @(negedge clk); tx_rst = 1'b0;
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (ack == lvl) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  // Target shows phase ph with REQ, so the phase is latched before start.
  task automatic present_phase(input logic [2:0] ph, input logic keep_req);
    bus_phase = ph; req = 1'b1;
    repeat (2) @(negedge clk);
    req = keep_req;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] ph, input int n);
    cmd_phase = ph; cmd_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic bit is_in(input logic [2:0] ph);
    return ph[0];
  endfunction

  task automatic run_move(input logic [2:0] ph, input int n);
    bit ok;
    clear_counts();
    for (int k = 0; k < 16; k++) begin
      tx_buf[k] = 8'($urandom);
      in_buf[k] = 8'($urandom);
    end
    tx_valid = ~is_in(ph);
    data_in = in_buf[0];
    present_phase(ph, 1'b1);
    issue(ph, n);
    for (int k = 0; k < n; k++) begin
      wait_ack(1'b1, ok);
      chk(ok, "R4 ack after req", int'(ack), 1);
      if (!is_in(ph)) begin
        chk(data_out == tx_buf[k] && data_oe, "R5 driven byte", int'(data_out), int'(tx_buf[k]));
      end else begin
        chk(!data_oe, "R1 inbound no drive", int'(data_oe), 0);
      end
      if (ph == 3'b110) chk(atn == (k != n-1), "R8 atn level", int'(atn), int'(k != n-1));
      req = 1'b0;
      if (k == n-1 && ph == 3'b111) begin
        repeat (3) @(negedge clk);
        chk(ack && busy, "R9 ack held", int'({ack, busy}), 3);
      end else begin
        wait_ack(1'b0, ok);
        chk(ok, "R4 ack release", int'(ack), 0);
      end
      if (k < n-1) begin
        data_in = in_buf[k+1];
        @(negedge clk);
        req = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R6 done once", done_cnt, 1);
    chk(irq_cnt == 0, "R6 no irq", irq_cnt, 0);
    if (is_in(ph)) begin
      chk(rx_n == n, "R4 byte count", rx_n, n);
      for (int k = 0; k < n; k++)
        chk(rx_buf[k] == in_buf[k], "R4 rx byte", int'(rx_buf[k]), int'(in_buf[k]));
    end else begin
      chk(tx_idx == n, "R5 bytes taken", tx_idx, n);
    end
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) begin tx_buf[k] = '0; in_buf[k] = '0; rx_buf[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tx_rst = 1'b0;
    // R12 reset state
    chk({ack, atn, data_oe, busy, done, irq, phase_oe} == 7'b0, "R12 reset outputs",
        int'({ack, atn, data_oe, busy, done, irq, phase_oe}), 0);

    // R2 mismatch at start
    clear_counts();
    present_phase(3'b000, 1'b0);
    issue(3'b001, 3);
    repeat (4) @(negedge clk);
    chk(irq_cnt == 1, "R2 irq", irq_cnt, 1);
    chk(!ack && !busy && done_cnt == 0, "R2 no transfer", int'({ack, busy}), 0);

    // R3 reserved codes
    for (int r = 4; r < 6; r++) begin
      clear_counts();
      present_phase(3'(r), 1'b0);
      issue(3'(r), 2);
      repeat (4) @(negedge clk);
      chk(irq_cnt == 1 && !busy && !ack, "R3 reserved mismatch", irq_cnt, 1);
    end

    // R6 zero count
    clear_counts();
    present_phase(3'b010, 1'b0);
    issue(3'b010, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && irq_cnt == 0 && !busy && !ack, "R6 zero count", done_cnt, 1);

    // R1 R4 R5 R6 random moves over data/command/status
    for (int t = 0; t < 12; t++) begin
      run_move(3'($urandom_range(0, 3)), $urandom_range(1, 6));
    end

    // R8 message-out with ATN
    atn_set = 1'b1; @(negedge clk); atn_set = 1'b0;
    chk(atn, "R8 atn set", int'(atn), 1);
    run_move(3'b110, 3);
    chk(!atn, "R8 atn released", int'(atn), 0);

    // R9 message-in ack hold and clear
    run_move(3'b111, 2);
    clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
    @(negedge clk);
    chk(!ack && !busy, "R9 clear ack", int'({ack, busy}), 0);

    // R10 clear-ack ignored when idle and while waiting for REQ
    clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
    @(negedge clk);
    chk(!ack && !busy, "R10 idle clear", int'({ack, busy}), 0);
    clear_counts();
    tx_buf[0] = 8'h5a;
    present_phase(3'b000, 1'b0);
    issue(3'b000, 1);
    clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
    @(negedge clk);
    chk(busy && !ack, "R10 waiting clear", int'({busy, ack}), 2);
    tx_valid = 1'b1; req = 1'b1;
    begin
      bit ok;
      wait_ack(1'b1, ok);
      chk(ok && data_out == 8'h5a, "R10 move continues", int'(data_out), 'h5a);
      req = 1'b0;
      wait_ack(1'b0, ok);
    end
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R10 move done", done_cnt, 1);

    // R7 phase change mid-move
    clear_counts();
    data_in = 8'h11;
    present_phase(3'b001, 1'b1);
    issue(3'b001, 4);
    begin
      bit ok;
      wait_ack(1'b1, ok);
      req = 1'b0;
      wait_ack(1'b0, ok);
    end
    bus_phase = 3'b011; data_in = 8'h22;
    @(negedge clk); req = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_cnt == 1, "R7 irq", irq_cnt, 1);
    chk(!ack && !busy && done_cnt == 0 && rx_n == 1, "R7 stopped", rx_n, 1);
    req = 1'b0;

    // R11 target mode
    clear_counts();
    tgt_mode = 1'b1;
    issue(3'b011, 5);
    tgt_mode = 1'b0;
    @(negedge clk);
    chk(phase_oe && phase_drv == 3'b011, "R11 phase driven", int'(phase_drv), 3);
    chk(done_cnt == 1 && !ack && !busy, "R11 no handshake", done_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule